// File: doc/BRIEF.md
# Four-Channel PCM Receive Deserializer

This block turns incoming serial PCM voice data into four 8-bit samples. A bit clock and a frame-start pulse arrive as plain inputs next to the data lines. A faster system clock samples all of them. Each falling bit-clock edge moves one data bit into a shift register. The frame-start rising edge marks the most significant bit of the first sample. When a byte is complete, it is copied into the output register of its channel, and that channel's valid strobe pulses.

The block has two capture modes. In lane-per-channel mode, each of the four data inputs carries one channel, and all four bytes complete together. In multiplexed mode, only the highest data input is used. It carries four consecutive byte slots after the frame start, in the order channel 1, 2, 3, 4. An idle timer watches the bit clock. If no edge arrives within a programmable number of system cycles, the block raises a power-save flag. After that, it ignores data until a new frame start arrives.

Top module: `pcm_rx4`

## Requirements
- R1: During and just after reset, every sample output is zero, no valid strobe is high, and the power-save flag is low.
- R2: In lane-per-channel mode (`mode_serial_i` = 0), data is taken on falling bit-clock edges, most significant bit first. The first bit is the first falling edge after a frame-start rising edge. Channel n (n = 1..4) comes from `din_i[n-1]` and appears on `sample_o[8n-1:8n-8]`.
- R3: In lane-per-channel mode, all four valid strobes pulse together for exactly one system cycle, once per frame. Bits after the eighth in a frame are ignored.
- R4: In multiplexed mode (`mode_serial_i` = 1), `din_i[3]` carries four 8-bit slots, most significant bit first, for channels 1, 2, 3 and 4 in that order. Each slot raises only its own channel's strobe, for one cycle.
- R5: In multiplexed mode, `din_i[2:0]` have no effect on any sample.
- R6: In multiplexed mode, bits after the 32nd in a frame are ignored.
- R7: A channel's output holds its value between strobes of that channel.
- R8: A frame-start rising edge in the middle of a frame restarts the bit count and discards the partial byte.
- R9: If a frame-start rising edge and a bit-clock falling edge are sampled in the same system cycle, that bit is the most significant bit of the new frame.
- R10: Power save asserts once the bit clock has stayed constant, either low or high, for about `idle_limit_i` system cycles.
- R11: The next bit-clock edge clears power save. No sample is captured after power save until a new frame-start rising edge arrives, and no strobe is issued while power save is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk_i | input | 1 | PCM bit clock, sampled |
| rsync_i | input | 1 | Frame-start pulse; its rising edge marks the first bit |
| mode_serial_i | input | 1 | 0 = one lane per channel, 1 = four channels multiplexed on `din_i[3]` |
| din_i | input | 4 | Serial data lanes, bit n-1 for channel n |
| idle_limit_i | input | 16 | Bit-clock idle time, in system cycles, before power save |
| sample_o | output | 32 | Four held samples, channel 1 in the low byte |
| sample_vld_o | output | 4 | One-cycle strobe for each channel when its byte is latched |
| psave_o | output | 1 | High while the bit clock is idle |

## Verification
The frame restart and the bit capture can fall in the same system cycle. This happens when the frame-start rise and a bit-clock fall pass through the input sampler together. The bench provokes this by raising the frame-start input in the exact system cycle that it drops the bit clock, right after a partial frame. The result is judged by whether each channel's next byte takes that bit as its most significant bit, and by whether exactly one strobe per channel appears for the new frame. A second collision, a frame start while power save is still high, comes from starting a frame straight after an idle period. The bench expects that frame to be captured normally.

// File: rtl/pcm_rx4_pkg.sv
package pcm_rx4_pkg;

    localparam int DEF_NUM_CH      = 4;
    localparam int DEF_SAMPLE_W    = 8;
    localparam int DEF_IDLE_W      = 16;
    localparam int DEF_SYNC_STAGES = 2;

    typedef enum logic {
        MODE_LANES = 1'b0,
        MODE_MUXED = 1'b1
    } rx_mode_e;

endpackage

// File: rtl/pcm_rx4_inedge.sv
// Samples the bit clock, frame start and data lanes into the system clock
// domain and reports edges of the sampled bit clock and frame start.
module pcm_rx4_inedge #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bclk_i,
    input  logic         rsync_i,
    input  logic [W-1:0] din_i,
    output logic         bclk_fall_o,
    output logic         bclk_edge_o,
    output logic         rsync_rise_o,
    output logic [W-1:0] din_o
);
    localparam int VW     = W + 2;
    localparam int BCLK_B = W;
    localparam int SYNC_B = W + 1;

    typedef struct packed {
        logic [STAGES:0][VW-1:0] pipe;
    } in_state_t;

    in_state_t st_d, st_q;
    logic [VW-1:0] cur, prev;

    always_comb begin
        st_d      = st_q;
        st_d.pipe = {st_q.pipe[STAGES-1:0], {rsync_i, bclk_i, din_i}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur          = st_q.pipe[STAGES-1];
    assign prev         = st_q.pipe[STAGES];
    assign bclk_fall_o  = prev[BCLK_B] & ~cur[BCLK_B];
    assign bclk_edge_o  = prev[BCLK_B] ^ cur[BCLK_B];
    assign rsync_rise_o = ~prev[SYNC_B] & cur[SYNC_B];
    assign din_o        = cur[W-1:0];
endmodule

// File: rtl/pcm_rx4_idle.sv
// Counts system cycles without a bit-clock edge and flags power save.
module pcm_rx4_idle #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             psave_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             psave;
    } idle_state_t;

    idle_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (edge_i) begin
            st_d.cnt   = '0;
            st_d.psave = 1'b0;
        end else begin
            if (st_q.cnt != {CNT_W{1'b1}}) st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt >= limit_i)       st_d.psave = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign psave_o = st_q.psave;
endmodule

// File: rtl/pcm_rx4_shift.sv
// One serial lane: shifts in a bit when enabled and offers the word that
// the current shift would complete.
module pcm_rx4_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en_i,
    input  logic         bit_i,
    output logic [W-1:0] word_o
);
    typedef struct packed {
        logic [W-1:0] sr;
    } sh_state_t;

    sh_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en_i) st_d.sr = {st_q.sr[W-2:0], bit_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_o = {st_q.sr[W-2:0], bit_i};
endmodule

// File: rtl/pcm_rx4.sv
// Four-channel PCM receive deserializer. SAMPLE_W must be a power of two.
module pcm_rx4
    import pcm_rx4_pkg::*;
#(
    parameter int NUM_CH      = DEF_NUM_CH,
    parameter int SAMPLE_W    = DEF_SAMPLE_W,
    parameter int IDLE_W      = DEF_IDLE_W,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bclk_i,
    input  logic                       rsync_i,
    input  logic                       mode_serial_i,
    input  logic [NUM_CH-1:0]          din_i,
    input  logic [IDLE_W-1:0]          idle_limit_i,
    output logic [NUM_CH*SAMPLE_W-1:0] sample_o,
    output logic [NUM_CH-1:0]          sample_vld_o,
    output logic                       psave_o
);
    localparam int SLOT_W      = $clog2(SAMPLE_W);
    localparam int CH_W        = $clog2(NUM_CH);
    localparam int FRAME_BITS  = NUM_CH * SAMPLE_W;
    localparam int CNT_W       = $clog2(FRAME_BITS + 1);
    localparam int SERIAL_LANE = NUM_CH - 1;

    typedef struct packed {
        logic                             armed;
        logic [CNT_W-1:0]                 cnt;
        logic [NUM_CH-1:0][SAMPLE_W-1:0]  sample;
        logic [NUM_CH-1:0]                vld;
    } frame_state_t;

    frame_state_t st_d, st_q;

    rx_mode_e                        mode;
    logic                            bclk_fall, bclk_edge, sync_rise, psave;
    logic [NUM_CH-1:0]               din_s;
    logic [NUM_CH-1:0]               lane_en;
    logic [NUM_CH-1:0][SAMPLE_W-1:0] word;
    logic [CNT_W-1:0]                frame_len, pos;
    logic [CH_W-1:0]                 slot_ch;
    logic                            take;

    assign mode = rx_mode_e'(mode_serial_i);

    pcm_rx4_inedge #(.W(NUM_CH), .STAGES(SYNC_STAGES)) u_in (
        .clk          (clk),
        .rst_n        (rst_n),
        .bclk_i       (bclk_i),
        .rsync_i      (rsync_i),
        .din_i        (din_i),
        .bclk_fall_o  (bclk_fall),
        .bclk_edge_o  (bclk_edge),
        .rsync_rise_o (sync_rise),
        .din_o        (din_s)
    );

    pcm_rx4_idle #(.CNT_W(IDLE_W)) u_idle (
        .clk     (clk),
        .rst_n   (rst_n),
        .edge_i  (bclk_edge),
        .limit_i (idle_limit_i),
        .psave_o (psave)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_lane
        pcm_rx4_shift #(.W(SAMPLE_W)) u_sh (
            .clk        (clk),
            .rst_n      (rst_n),
            .shift_en_i (lane_en[i]),
            .bit_i      (din_s[i]),
            .word_o     (word[i])
        );
        assign sample_o[i*SAMPLE_W +: SAMPLE_W] = st_q.sample[i];
    end

    always_comb begin
        st_d      = st_q;
        st_d.vld  = '0;
        lane_en   = '0;
        frame_len = (mode == MODE_MUXED) ? CNT_W'(FRAME_BITS) : CNT_W'(SAMPLE_W);
        pos       = sync_rise ? '0 : st_q.cnt;
        slot_ch   = pos[SLOT_W +: CH_W];
        take      = bclk_fall && (sync_rise || (st_q.armed && (st_q.cnt < frame_len)));

        if (psave) st_d.armed = 1'b0;
        if (sync_rise) begin
            st_d.armed = 1'b1;
            st_d.cnt   = '0;
        end

        if (take) begin
            st_d.cnt = pos + 1'b1;
            if (mode == MODE_MUXED) lane_en[SERIAL_LANE] = 1'b1;
            else                    lane_en = '1;
            if (pos[SLOT_W-1:0] == SLOT_W'(SAMPLE_W - 1)) begin
                if (mode == MODE_MUXED) begin
                    st_d.sample[slot_ch] = word[SERIAL_LANE];
                    st_d.vld[slot_ch]    = 1'b1;
                end else begin
                    st_d.sample = word;
                    st_d.vld    = '1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sample_vld_o = st_q.vld;
    assign psave_o      = psave;
endmodule

// File: rtl/pcm_rx4_chk.sv
module pcm_rx4_chk #(
    parameter int NUM_CH   = 4,
    parameter int SAMPLE_W = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       mode_serial_i,
    input logic [NUM_CH*SAMPLE_W-1:0] sample_o,
    input logic [NUM_CH-1:0]          sample_vld_o,
    input logic                       psave_o
);
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_vld_o != '0) |=> (sample_vld_o == '0))
        else $error("strobe longer than one cycle"); // R3

    AST_LANES_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_serial_i && $stable(mode_serial_i) && (sample_vld_o != '0)) |-> (&sample_vld_o))
        else $error("lane strobes not simultaneous"); // R3

    AST_MUX_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_serial_i && $stable(mode_serial_i)) |-> $onehot0(sample_vld_o))
        else $error("more than one slot strobe"); // R4

    AST_SAMPLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_vld_o == '0) |-> $stable(sample_o))
        else $error("sample changed without strobe"); // R7

    AST_PSAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        psave_o |-> (sample_vld_o == '0))
        else $error("strobe during power save"); // R11
endmodule

bind pcm_rx4 pcm_rx4_chk #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_serial_i (mode_serial_i),
    .sample_o      (sample_o),
    .sample_vld_o  (sample_vld_o),
    .psave_o       (psave_o)
);

// File: tb/sim_pcm_rx4.sv
module sim_pcm_rx4;
    localparam int NCH = 4;
    localparam int SW  = 8;
    localparam int IW  = 16;

    logic clk = 1'b0, rst_n = 1'b0, bclk = 1'b0, rsync = 1'b0, mode_ser = 1'b0;
    logic [NCH-1:0]    din   = '0;
    logic [IW-1:0]     limit = 16'd40;
    logic [NCH*SW-1:0] sample;
    logic [NCH-1:0]    vld;
    logic              psave;

    always #10 clk = ~clk;

    pcm_rx4 #(.NUM_CH(NCH), .SAMPLE_W(SW), .IDLE_W(IW), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .rsync_i(rsync),
        .mode_serial_i(mode_ser), .din_i(din), .idle_limit_i(limit),
        .sample_o(sample), .sample_vld_o(vld), .psave_o(psave)
    );

    int checks = 0, errors = 0;
    bit finished = 1'b0;
    int vcnt [NCH];
    int base [NCH];
    logic [SW-1:0] vlast [NCH];

    initial for (int c = 0; c < NCH; c++) begin vcnt[c] = 0; vlast[c] = '0; end

    always @(negedge clk)
        if (rst_n)
            for (int c = 0; c < NCH; c++)
                if (vld[c]) begin
                    vcnt[c]++;
                    vlast[c] = sample[c*SW +: SW];
                end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic snap();
        for (int c = 0; c < NCH; c++) base[c] = vcnt[c];
    endtask

    // sy: 0 none, 1 frame start with the bit-clock rise, 2 frame start at the fall
    task automatic tx_bit(input logic [NCH-1:0] b, input int sy);
        bclk  = 1'b1;
        din   = b;
        rsync = (sy == 1);
        repeat (4) @(negedge clk);
        bclk = 1'b0;
        if (sy == 2) rsync = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_lanes(input logic [NCH-1:0][SW-1:0] v, input int sy_first);
        for (int k = 0; k < SW; k++) begin
            logic [NCH-1:0] b;
            for (int c = 0; c < NCH; c++) b[c] = v[c][SW-1-k];
            tx_bit(b, (k == 0) ? sy_first : 0);
        end
    endtask

    task automatic expect_frame(input string req, input logic [NCH-1:0][SW-1:0] v, input int n);
        for (int c = 0; c < NCH; c++) begin
            check(req, $sformatf("strobe count ch%0d", c + 1), vcnt[c] - base[c], n);
            check(req, $sformatf("sample ch%0d", c + 1), {24'd0, sample[c*SW +: SW]}, {24'd0, v[c]});
        end
    endtask

    task automatic t_reset();
        check("R1", "sample during reset", sample, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "sample after reset", sample, 32'd0);
        check("R1", "strobes after reset", {28'd0, vld}, 32'd0);
        check("R1", "power save after reset", {31'd0, psave}, 32'd0);
    endtask

    task automatic t_lanes();
        logic [NCH-1:0][SW-1:0] v;
        mode_ser = 1'b0;
        v = {8'h81, 8'h0F, 8'h3C, 8'hA5};
        snap();
        send_lanes(v, 1);
        expect_frame("R2", v, 1);
        for (int k = 0; k < SW; k++) tx_bit(4'hF, 0);   // trailing bits, no frame start
        expect_frame("R3", v, 1);
        check("R7", "hold after trailing bits", sample, v);
        v = {8'h5A, 8'hC3, 8'hFE, 8'h01};
        snap();
        send_lanes(v, 1);
        expect_frame("R2", v, 1);
    endtask

    task automatic t_muxed();
        logic [NCH-1:0][SW-1:0] v;
        mode_ser = 1'b1;
        v = {8'h96, 8'h4B, 8'hE1, 8'h27};
        snap();
        for (int k = 0; k < NCH * SW; k++) begin
            logic bt;
            logic [NCH-1:0] b;
            bt = v[k / SW][SW-1-(k % SW)];
            b  = {NCH{~bt}};
            b[NCH-1] = bt;
            tx_bit(b, (k == 0) ? 1 : 0);
        end
        for (int c = 0; c < NCH; c++) begin
            check("R4", $sformatf("slot strobe ch%0d", c + 1), vcnt[c] - base[c], 1);
            check("R5", $sformatf("slot value ch%0d", c + 1), {24'd0, vlast[c]}, {24'd0, v[c]});
        end
        for (int k = 0; k < SW; k++) tx_bit(4'h7, 0);   // beyond the 32nd bit
        expect_frame("R6", v, 1);
        mode_ser = 1'b0;
    endtask

    task automatic t_midsync();
        logic [NCH-1:0][SW-1:0] v;
        v = {8'h33, 8'hCC, 8'h69, 8'hF0};
        snap();
        tx_bit(4'hF, 1);
        tx_bit(4'h0, 0);
        tx_bit(4'hF, 0);
        send_lanes(v, 1);
        expect_frame("R8", v, 1);
    endtask

    task automatic t_coincide();
        logic [NCH-1:0][SW-1:0] v;
        v = {8'hB7, 8'h48, 8'h9D, 8'h62};
        snap();
        tx_bit(4'hF, 1);
        tx_bit(4'hA, 0);
        send_lanes(v, 2);
        expect_frame("R9", v, 1);
    endtask

    task automatic t_psave();
        logic [NCH-1:0][SW-1:0] v;
        repeat (30) @(negedge clk);
        check("R10", "not yet idle (low)", {31'd0, psave}, 32'd0);
        repeat (30) @(negedge clk);
        check("R10", "idle with clock low", {31'd0, psave}, 32'd1);
        bclk = 1'b1;
        repeat (10) @(negedge clk);
        check("R11", "cleared by rising edge", {31'd0, psave}, 32'd0);
        repeat (70) @(negedge clk);
        check("R10", "idle with clock high", {31'd0, psave}, 32'd1);
        snap();
        for (int k = 0; k < SW; k++) tx_bit(4'h5, 0);
        check("R11", "cleared after edges", {31'd0, psave}, 32'd0);
        for (int c = 0; c < NCH; c++)
            check("R11", $sformatf("no capture before frame start ch%0d", c + 1),
                  vcnt[c] - base[c], 0);
        repeat (60) @(negedge clk);
        v = {8'h12, 8'h34, 8'h56, 8'h78};
        snap();
        send_lanes(v, 1);
        expect_frame("R11", v, 1);
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        t_lanes();
        t_muxed();
        t_midsync();
        t_coincide();
        t_psave();
        repeat (10) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end
endmodule